// File: doc/BRIEF.md
# Rational-ratio clock generator

The block derives a slow square wave from a fast reference. The reference comes in as clock-enable strobes on four candidate lines, and a control word picks one of them. The output toggles at a rate of reference × M / N. M is a 9-bit numerator and N is a 20-bit denominator. Because N must be at least twice M, the output can run at most at half the strobe rate.

Software writes a 32-bit control word and can read it back. The word holds the line select, a run enable and both coefficients. A phase accumulator gains 2·M on each selected strobe. When the sum reaches N, N is taken off and the output level flips. Every rising edge of the output also produces a one-cycle tick.

An illegal coefficient pair keeps the output low and raises a sticky error flag. A coefficient change made while the output is running waits for the next output edge, so no period is cut short.

Top module: `mn_clkgen`

## Requirements
- R1: The control word is laid out as bits 31:30 line select, bit 29 run enable, bits 28:20 numerator M, and bits 19:0 denominator N. `rd_data` returns the last word written; after reset it is zero.
- R2: Counting from the first strobe after the output starts, with the output beginning low, the output has toggled floor(2·M·k/N) times after k selected strobes. Over many strobes this gives a frequency of strobe rate × M / N.
- R3: Only the strobe line whose index equals bits 31:30 advances the output. Activity on the other three lines has no effect.
- R4: A pair is legal when 1 ≤ M ≤ 511, 2 ≤ N ≤ 1048575 and N ≥ 2·M. An enabled but illegal pair holds `clk_out` low. M=511 with N=1022 is legal and toggles on every strobe.
- R5: `cfg_err` becomes 1 on any write whose coefficient pair is illegal, whatever the enable bit. It stays 1 until a write with a legal pair, which clears it.
- R6: A write that clears bit 29 drives `clk_out` low on the following clock and empties the accumulator. After the output is enabled again, counting restarts from zero.
- R7: `rise_tick` is high for exactly the one cycle in which `clk_out` has just gone from low to high, and at no other time.
- R8: M and N written while the output runs take effect only at the next output toggle. The toggle in progress completes with the old values.
- R9: After reset, `clk_out`, `rise_tick` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Loads `wr_data` into the control word |
| wr_data | input | 32 | New control word |
| ref_stb | input | 4 | Reference enable strobes, one per selectable line |
| rd_data | output | 32 | Current control word |
| clk_out | output | 1 | Registered divided square wave |
| rise_tick | output | 1 | One-cycle pulse on each output rise |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
Some properties hold on every cycle and are checked that way. A cleared enable or a raised error forces the output low on the next clock. The tick coincides only with a fresh rising edge. Every rise is caused by a strobe on the line currently selected, and only while the enable is set.

Other behaviours can only be shown by the bench scenarios. These are:
- the exact toggle count for a given M, N and number of strobes;
- the deferral of new coefficients until the next toggle;
- the emptying of the accumulator across a disable;
- the immunity to strobes on unselected lines.

// File: rtl/mn_clkgen.sv
module mn_clkgen #(
  parameter int MW = 9,
  parameter int NW = 20,
  parameter int SW = 2,
  localparam int CW = SW + 1 + MW + NW,
  localparam int AW = NW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_data,
  input  logic [2**SW-1:0]  ref_stb,
  output logic [CW-1:0]     rd_data,
  output logic              clk_out,
  output logic              rise_tick,
  output logic              cfg_err
);
  localparam int EN_B = MW + NW;

  function automatic logic legal(input logic [MW-1:0] m, input logic [NW-1:0] n);
    return (m != '0) && (n >= NW'(2)) && (AW'(n) >= AW'({m, 1'b0}));
  endfunction

  logic [CW-1:0] ctrl;
  logic [MW-1:0] act_m;
  logic [NW-1:0] act_n;
  logic [AW-1:0] acc;
  logic          running;

  wire [MW-1:0] c_m   = ctrl[NW +: MW];
  wire [NW-1:0] c_n   = ctrl[NW-1:0];
  wire [SW-1:0] c_sel = ctrl[CW-1 -: SW];
  wire          ok    = ctrl[EN_B] && legal(c_m, c_n);
  wire          stb   = ref_stb[c_sel];
  wire [AW-1:0] sum   = acc + AW'({act_m, 1'b0});
  wire          wrap  = sum >= AW'(act_n);

  assign rd_data = ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      cfg_err   <= 1'b0;
      act_m     <= '0;
      act_n     <= '0;
      acc       <= '0;
      running   <= 1'b0;
      clk_out   <= 1'b0;
      rise_tick <= 1'b0;
    end else begin
      rise_tick <= 1'b0;
      if (wr_en) begin
        ctrl    <= wr_data;
        cfg_err <= !legal(wr_data[NW +: MW], wr_data[NW-1:0]);
      end
      if (!ok) begin
        running <= 1'b0;
        acc     <= '0;
        clk_out <= 1'b0;
      end else if (!running) begin
        running <= 1'b1;
        act_m   <= c_m;
        act_n   <= c_n;
        acc     <= '0;
      end else if (stb) begin
        if (wrap) begin
          acc       <= sum - AW'(act_n);
          clk_out   <= !clk_out;
          rise_tick <= !clk_out;
          act_m     <= c_m;
          act_n     <= c_n;
        end else begin
          acc <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/mn_clkgen_chk.sv
module mn_clkgen_chk #(
  parameter int MW = 9,
  parameter int NW = 20,
  parameter int SW = 2,
  localparam int CW = SW + 1 + MW + NW
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2**SW-1:0] ref_stb,
  input logic [CW-1:0]    rd_data,
  input logic             clk_out,
  input logic             rise_tick,
  input logic             cfg_err
);
  // R6
  off_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[MW+NW] |=> !clk_out);

  // R4
  err_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !clk_out);

  // R7
  tick_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (clk_out && !$past(clk_out)));

  // R7
  rise_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> rise_tick);

  // R3
  rise_needs_sel_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(ref_stb[rd_data[CW-1 -: SW]]));

  // R6
  rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(rd_data[MW+NW]));
endmodule

bind mn_clkgen mn_clkgen_chk #(.MW(MW), .NW(NW), .SW(SW)) u_chk (.*);

// File: tb/tb_mn_clkgen.sv
module tb_mn_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  ref_stb = '0;
  logic [31:0] rd_data;
  logic        clk_out, rise_tick, cfg_err;

  int n_chk = 0, n_fail = 0;
  int got_ticks, got_rises;
  bit done = 0;
  longint exp_q[$];
  string  tag_q[$];
  event   win_done;

  mn_clkgen dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                 .ref_stb(ref_stb), .rd_data(rd_data), .clk_out(clk_out),
                 .rise_tick(rise_tick), .cfg_err(cfg_err));

  always #2 clk = ~clk;

  function automatic logic [31:0] word(int sel, int en, int m, int n);
    return {sel[1:0], en[0], m[8:0], n[19:0]};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Pulses the selected line k times (every other cycle) while the other lines stay high.
  task automatic pulse(int k, int src);
    logic prev;
    got_ticks = 0; got_rises = 0; prev = clk_out;
    for (int i = 0; i < 2 * k; i++) begin
      @(negedge clk);
      if (rise_tick) got_ticks++;
      if (clk_out && !prev) got_rises++;
      prev = clk_out;
      ref_stb = (i % 2 == 0) ? 4'hF : (4'hF & ~(4'b1 << src));
    end
    @(negedge clk);
    if (rise_tick) got_ticks++;
    if (clk_out && !prev) got_rises++;
    ref_stb = '0;
  endtask

  task automatic window(int m, int n, int src, int k, string tag);
    longint t;
    t = (2 * longint'(m) * k) / n;
    exp_q.push_back((t + 1) / 2);
    tag_q.push_back(tag);
    wr(word(src, 0, m, n));
    wr(word(src, 1, m, n));
    pulse(k, src);
    ->win_done;
    @(negedge clk);
  endtask

  // Scoreboard monitor
  initial forever begin
    longint e;
    string  tg;
    @(win_done);
    e = exp_q.pop_front();
    tg = tag_q.pop_front();
    chk(got_ticks == e, {tg, " ticks"}, got_ticks, e);
    chk(got_rises == e, {tg, " rises"}, got_rises, e);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk(clk_out == 0, "R9 clk_out", clk_out, 0);
    chk(rise_tick == 0, "R9 rise_tick", rise_tick, 0);
    chk(cfg_err == 0, "R9 cfg_err", cfg_err, 0);
    chk(rd_data == 0, "R1 reset word", rd_data, 0);
    rst_n = 1'b1;

    // R1 readback
    wr(word(1, 0, 37, 12345));
    chk(rd_data == word(1, 0, 37, 12345), "R1 readback", rd_data, word(1, 0, 37, 12345));

    // R2 ratios
    window(1, 4, 0, 40, "R2 1/4");
    window(3, 10, 1, 50, "R2 3/10");
    window(5, 17, 0, 51, "R2 5/17");
    // R4 legal extremes
    window(511, 1022, 3, 20, "R4 511/1022");
    window(1, 1048575, 0, 100, "R4 maxN");
    // R3 other lines held high
    window(2, 9, 2, 45, "R3 src2");

    // R4 / R5 illegal settings
    wr(word(0, 0, 0, 0)); wr(word(0, 1, 0, 4));
    chk(cfg_err == 1, "R5 M=0 err", cfg_err, 1);
    pulse(10, 0);
    chk(got_ticks == 0 && clk_out == 0, "R4 M=0 held low", got_ticks, 0);
    wr(word(0, 1, 1, 1));
    chk(cfg_err == 1, "R5 N=1 err", cfg_err, 1);
    wr(word(0, 1, 3, 5));
    pulse(10, 0);
    chk(cfg_err == 1, "R5 N<2M sticky", cfg_err, 1);
    chk(got_ticks == 0 && clk_out == 0, "R4 N<2M held low", got_ticks, 0);
    window(3, 6, 0, 4, "R5 legal run");
    chk(cfg_err == 0, "R5 cleared", cfg_err, 0);

    // R6 disable forces low
    wr(word(0, 0, 1, 4)); wr(word(0, 1, 1, 4));
    pulse(2, 0);
    chk(clk_out == 1, "R6 setup high", clk_out, 1);
    wr(word(0, 0, 1, 4));
    chk(rd_data[29] == 0, "R1 enable readback", rd_data[29], 0);
    @(negedge clk);
    chk(clk_out == 0, "R6 forced low", clk_out, 0);
    // R6 accumulator cleared
    wr(word(0, 1, 1, 4));
    pulse(1, 0);
    wr(word(0, 0, 1, 4)); wr(word(0, 1, 1, 4));
    pulse(1, 0);
    chk(clk_out == 0, "R6 acc cleared", clk_out, 0);

    // R8 coefficient change waits for toggle
    wr(word(0, 0, 1, 4)); wr(word(0, 1, 1, 4));
    pulse(1, 0);
    wr(word(0, 1, 1, 40));
    pulse(1, 0);
    chk(clk_out == 1, "R8 old ratio completes", clk_out, 1);
    pulse(5, 0);
    chk(clk_out == 1, "R8 new ratio in force", clk_out, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule